// File: doc/BRIEF.md
# Ethernet Transmit Status Register Unit

This unit holds the status word that a half-duplex Ethernet transmit path reports for each frame. The transmit engine feeds it single-cycle event strobes: frame start, frame end, collision, transmit underrun, interframe-gap start, SQE test result, event-counter saturation and counter-register read. It also receives level inputs for carrier, deferral wait and destination type, plus a byte-time tick that pulses once per eight bit times. The unit measures frame position, deferral time and the interframe-gap window itself, and it counts collisions per frame. It also owns the transmit-enable control bit, which software arms and which fatal errors force off.

Every status bit follows its own set and clear rule. Fatal errors stay set until software re-arms transmit enable. Timing flags clear when a frame ends. Destination flags clear when a frame starts. When a set and a clear reach the same bit in the same cycle, the set takes effect. At every frame end the unit presents a one-cycle snapshot of the complete word so that it can be stored with the packet. The live word keeps changing with later frames.

Top module: `tx_status_unit`

Status word layout: bit 0 transmit enable, bit 1 link OK, bit 2 underrun, bit 3 late collision, bit 4 sixteen collisions, bit 5 SQE, bit 6 excessive deferral, bit 7 deferred, bit 8 broadcast, bit 9 multicast, bit 10 counter rollover, bits 15..11 zero.

## Requirements
- R1: After reset, `status_word` is 0, `tx_enable` is 0, and `snap_valid`, `status_irq` and `link_irq` are 0.
- R2: A `txen_wr` with `txen_wdata`=1 sets bit 0, and with 0 clears it. A write of 1 (re-arm) also clears bits 2, 3, 4 and 5.
- R3: An `underrun` strobe sets bit 2 and forces bit 0 to 0. If a re-arm write arrives in the same cycle, the forced clear of bit 0 takes precedence and bit 2 still sets.
- R4: A collision arriving more than 64 byte ticks after frame start sets bit 3 and clears bit 0. A collision at 64 or fewer ticks is counted as an ordinary collision and does not set bit 3.
- R5: The 16th ordinary collision of one frame sets bit 4 and clears bit 0. The 15th collision does not set it. The count restarts at each frame start.
- R6: Bit 6 sets on the 3037th byte tick that arrives while `defer_wait` is high (more than 3036 ticks of deferral). Both the bit and the deferral count clear at frame end.
- R7: Bit 7 sets when `carrier` is high within the 8 byte ticks after `gap_start`. Carrier after that window has no effect. Bit 7 clears at frame end.
- R8: At frame start, bit 8 takes the value of `dest_bcast` and bit 9 takes the value of `dest_mcast`. Both then hold until the next frame start.
- R9: An `sqe_seen` strobe sets bit 5 unless `full_duplex` is high. When `stop_on_sqe` is also high, bit 0 is forced to 0 and `status_irq` pulses for one cycle.
- R10: `cnt_hit15` sets bit 10 and `cnt_rd` clears it. If both arrive in the same cycle, the bit is set.
- R11: Bit 1 equals the inverse of `link_n`, one cycle later. Each change of bit 1 produces a one-cycle pulse on `link_irq` in the same cycle.
- R12: One cycle after `frame_end`, `snap_valid` is high for one cycle. `snap_word` then holds the word with that cycle's new set events included and before the frame-end clears are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_tick | input | 1 | One pulse per byte time |
| frame_start | input | 1 | Transmit frame begins |
| frame_end | input | 1 | Transmit frame completes |
| coll | input | 1 | Collision seen on current frame |
| underrun | input | 1 | Transmit data underrun |
| gap_start | input | 1 | Interframe gap begins |
| carrier | input | 1 | Carrier sense level |
| defer_wait | input | 1 | Pending frame is deferring |
| dest_bcast | input | 1 | Destination is broadcast (sampled at frame start) |
| dest_mcast | input | 1 | Destination is multicast (sampled at frame start) |
| sqe_seen | input | 1 | SQE test signal observed |
| full_duplex | input | 1 | Switched full-duplex mode |
| stop_on_sqe | input | 1 | Halt transmit when SQE sets |
| txen_wr | input | 1 | Write strobe for transmit enable |
| txen_wdata | input | 1 | Value written to transmit enable |
| cnt_hit15 | input | 1 | An event counter reached 15 |
| cnt_rd | input | 1 | Counter register was read |
| link_n | input | 1 | Active-low link indication |
| tx_enable | output | 1 | Transmit enable control bit |
| status_word | output | 16 | Live status word |
| status_irq | output | 1 | Pulse on SQE stop |
| link_irq | output | 1 | Pulse on link change |
| snap_valid | output | 1 | Snapshot strobe |
| snap_word | output | 16 | Status word for the finished frame |

## Verification
The collision input is driven at byte positions 64 and 65 into a frame, which separates an ordinary collision from a late one. Runs of 15 and 16 collisions bracket the abort count, and a repeat of 15 after a new frame start shows that the count restarts. Deferral is held for 3036 and then 3037 ticks. Carrier is raised at the last tick inside the gap window and again just outside it, so each boundary is probed from both sides. Same-cycle pairings (underrun with re-arm, counter hit with counter read, a set event at frame end) show whether set events beat clears. Snapshots are queued as expected values and compared when the strobe appears.

// File: rtl/txs_pkg.sv
// Shared constants for the transmit status unit: flag indices and word packing.
// Assumes a 16-bit status word with flags starting at bit 2.
package txs_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned NFLAG  = 9;
    localparam int unsigned F_UNDR = 0;  // word bit 2
    localparam int unsigned F_LATE = 1;  // word bit 3
    localparam int unsigned F_C16  = 2;  // word bit 4
    localparam int unsigned F_SQE  = 3;  // word bit 5
    localparam int unsigned F_EXC  = 4;  // word bit 6
    localparam int unsigned F_DEFR = 5;  // word bit 7
    localparam int unsigned F_BC   = 6;  // word bit 8
    localparam int unsigned F_MC   = 7;  // word bit 9
    localparam int unsigned F_ROLL = 8;  // word bit 10

    // Assemble the status word from the flag vector, link and enable bits.
    function automatic logic [WORD_W-1:0] pack_word(input logic [NFLAG-1:0] f,
                                                    input logic link,
                                                    input logic en);
        return {{(WORD_W-NFLAG-2){1'b0}}, f, link, en};
    endfunction
endpackage

// File: rtl/txs_frame_timer.sv
// Tracks the byte position inside the current frame and flags the late window.
// Assumes frame_start resets the position; the counter saturates beyond the limit.
module txs_frame_timer #(
    parameter int unsigned LATE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic byte_tick,
    output logic late_window
);
    localparam int unsigned POS_W = $clog2(LATE_LIMIT + 2);

    logic [POS_W-1:0] pos_q;

    // Count byte ticks since frame start, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            pos_q <= '0;
        else if (byte_tick && (pos_q <= POS_W'(LATE_LIMIT)))
            pos_q <= pos_q + 1'b1;
    end

    assign late_window = (pos_q > POS_W'(LATE_LIMIT));

    assert_pos_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_W'(LATE_LIMIT + 1));
endmodule

// File: rtl/txs_coll_counter.sv
// Splits collisions into late and ordinary ones and counts ordinary ones per frame.
// Assumes late_window comes from the frame timer; counts restart at frame start.
module txs_coll_counter #(
    parameter int unsigned MAX_COLL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic coll,
    input  logic late_window,
    output logic latcol_set,
    output logic col16_set
);
    localparam int unsigned CNT_W = $clog2(MAX_COLL + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             normal_hit;

    assign normal_hit = coll && !late_window;
    assign latcol_set = coll && late_window;
    assign col16_set  = normal_hit && (cnt_q == CNT_W'(MAX_COLL - 1));

    // Count ordinary collisions of this frame, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            cnt_q <= '0;
        else if (normal_hit && (cnt_q < CNT_W'(MAX_COLL)))
            cnt_q <= cnt_q + 1'b1;
    end

    assert_coll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_COLL));
    assert_coll_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(latcol_set && col16_set));
endmodule

// File: rtl/txs_defer_timer.sv
// Measures deferral time for excessive-deferral and the carrier window after gap start.
// Assumes byte_tick is one cycle wide; frame_end restarts deferral measurement.
module txs_defer_timer #(
    parameter int unsigned EXC_LIMIT = 3036,
    parameter int unsigned IFG_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_tick,
    input  logic defer_wait,
    input  logic frame_end,
    input  logic gap_start,
    input  logic carrier,
    output logic exc_set,
    output logic defr_set
);
    localparam int unsigned D_W = $clog2(EXC_LIMIT + 2);
    localparam int unsigned W_W = $clog2(IFG_TICKS + 1);

    logic [D_W-1:0] dcnt_q;
    logic [W_W-1:0] win_q;

    assign exc_set  = defer_wait && byte_tick && (dcnt_q == D_W'(EXC_LIMIT));
    assign defr_set = carrier && (win_q != '0);

    // Accumulate deferral ticks for the current frame, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end)
            dcnt_q <= '0;
        else if (defer_wait && byte_tick && (dcnt_q <= D_W'(EXC_LIMIT)))
            dcnt_q <= dcnt_q + 1'b1;
    end

    // Open the gap window on gap start and close it after the set number of ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (gap_start)
            win_q <= W_W'(IFG_TICKS);
        else if (byte_tick && (win_q != '0))
            win_q <= win_q - 1'b1;
    end

    assert_defer_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt_q <= D_W'(EXC_LIMIT + 1));
    assert_win_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_q <= W_W'(IFG_TICKS));
endmodule

// File: rtl/tx_status_unit.sv
// Transmit status word: applies each bit's set and clear rule, owns transmit enable,
// syncs the link input and emits a snapshot at each frame end.
// Assumes all event inputs are single-cycle strobes synchronous to clk.
module tx_status_unit
    import txs_pkg::*;
#(
    parameter int unsigned LATE_LIMIT = 64,
    parameter int unsigned MAX_COLL   = 16,
    parameter int unsigned EXC_LIMIT  = 3036,
    parameter int unsigned IFG_TICKS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_tick,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              coll,
    input  logic              underrun,
    input  logic              gap_start,
    input  logic              carrier,
    input  logic              defer_wait,
    input  logic              dest_bcast,
    input  logic              dest_mcast,
    input  logic              sqe_seen,
    input  logic              full_duplex,
    input  logic              stop_on_sqe,
    input  logic              txen_wr,
    input  logic              txen_wdata,
    input  logic              cnt_hit15,
    input  logic              cnt_rd,
    input  logic              link_n,
    output logic              tx_enable,
    output logic [WORD_W-1:0] status_word,
    output logic              status_irq,
    output logic              link_irq,
    output logic              snap_valid,
    output logic [WORD_W-1:0] snap_word
);
    logic late_window, latcol_set, col16_set, exc_set, defr_set;
    logic sqe_set, rearm, force_off, txen_d;
    logic link_q, link_prev;
    logic [NFLAG-1:0] flag_q, set_v, clr_v;

    txs_frame_timer #(.LATE_LIMIT(LATE_LIMIT)) u_frame (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .byte_tick(byte_tick), .late_window(late_window));

    txs_coll_counter #(.MAX_COLL(MAX_COLL)) u_coll (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .coll(coll),
        .late_window(late_window), .latcol_set(latcol_set), .col16_set(col16_set));

    txs_defer_timer #(.EXC_LIMIT(EXC_LIMIT), .IFG_TICKS(IFG_TICKS)) u_defer (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .defer_wait(defer_wait),
        .frame_end(frame_end), .gap_start(gap_start), .carrier(carrier),
        .exc_set(exc_set), .defr_set(defr_set));

    assign sqe_set   = sqe_seen && !full_duplex;
    assign rearm     = txen_wr && txen_wdata;
    assign force_off = underrun || latcol_set || col16_set || (sqe_set && stop_on_sqe);

    // Gather the set and clear events for every sticky flag.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[F_UNDR] = underrun;
        set_v[F_LATE] = latcol_set;
        set_v[F_C16]  = col16_set;
        set_v[F_SQE]  = sqe_set;
        set_v[F_EXC]  = exc_set;
        set_v[F_DEFR] = defr_set;
        set_v[F_BC]   = frame_start && dest_bcast;
        set_v[F_MC]   = frame_start && dest_mcast;
        set_v[F_ROLL] = cnt_hit15;
        clr_v[F_UNDR] = rearm;
        clr_v[F_LATE] = rearm;
        clr_v[F_C16]  = rearm;
        clr_v[F_SQE]  = rearm;
        clr_v[F_EXC]  = frame_end;
        clr_v[F_DEFR] = frame_end;
        clr_v[F_BC]   = frame_start;
        clr_v[F_MC]   = frame_start;
        clr_v[F_ROLL] = cnt_rd;
    end

    // One register per flag; a set in the same cycle overrides a clear.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_v[i])
                flag_q[i] <= 1'b1;
            else if (clr_v[i])
                flag_q[i] <= 1'b0;
        end
    end

    // Next transmit enable: fatal events beat a software write.
    always_comb begin
        if (force_off)
            txen_d = 1'b0;
        else if (txen_wr)
            txen_d = txen_wdata;
        else
            txen_d = tx_enable;
    end

    // Hold transmit enable and the SQE stop interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_enable  <= 1'b0;
            status_irq <= 1'b0;
        end else begin
            tx_enable  <= txen_d;
            status_irq <= sqe_set && stop_on_sqe;
        end
    end

    // Register the inverted link input and its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q    <= 1'b0;
            link_prev <= 1'b0;
        end else begin
            link_q    <= !link_n;
            link_prev <= link_q;
        end
    end

    assign link_irq    = link_q ^ link_prev;
    assign status_word = pack_word(flag_q, link_q, tx_enable);

    // Capture the frame's word, with this cycle's sets, at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_valid <= 1'b0;
            snap_word  <= '0;
        end else begin
            snap_valid <= frame_end;
            if (frame_end)
                snap_word <= pack_word(flag_q | set_v, link_q, txen_d);
        end
    end

    assert_underrun_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (!tx_enable && status_word[2]));
    assert_latcol_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latcol_set |=> (!tx_enable && status_word[3]));
    assert_col16_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col16_set |=> (!tx_enable && status_word[4]));
    assert_snap_after_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |-> $past(frame_end));
    assert_link_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_irq |-> (status_word[1] != $past(status_word[1])));
    assert_roll_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit15 && cnt_rd) |=> status_word[10]);
endmodule

// File: tb/test_tx_status_unit.sv
`timescale 1ns/1ps
module test_tx_status_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_tick = 0, frame_start = 0, frame_end = 0, coll = 0, underrun = 0;
    logic gap_start = 0, carrier = 0, defer_wait = 0, dest_bcast = 0, dest_mcast = 0;
    logic sqe_seen = 0, full_duplex = 0, stop_on_sqe = 0, txen_wr = 0, txen_wdata = 0;
    logic cnt_hit15 = 0, cnt_rd = 0, link_n = 1;
    logic tx_enable, status_irq, link_irq, snap_valid;
    logic [15:0] status_word, snap_word;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    tx_status_unit i_tx_status_unit (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .frame_start(frame_start),
        .frame_end(frame_end), .coll(coll), .underrun(underrun), .gap_start(gap_start),
        .carrier(carrier), .defer_wait(defer_wait), .dest_bcast(dest_bcast),
        .dest_mcast(dest_mcast), .sqe_seen(sqe_seen), .full_duplex(full_duplex),
        .stop_on_sqe(stop_on_sqe), .txen_wr(txen_wr), .txen_wdata(txen_wdata),
        .cnt_hit15(cnt_hit15), .cnt_rd(cnt_rd), .link_n(link_n), .tx_enable(tx_enable),
        .status_word(status_word), .status_irq(status_irq), .link_irq(link_irq),
        .snap_valid(snap_valid), .snap_word(snap_word));

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        byte_tick = 1;
        repeat (n) step();
        byte_tick = 0;
    endtask

    task automatic arm();
        txen_wr = 1; txen_wdata = 1; step(); txen_wr = 0; txen_wdata = 0;
    endtask

    task automatic end_frame(input logic [15:0] exp);
        exp_q.push_back(exp);
        frame_end = 1; step(); frame_end = 0;
    endtask

    // Monitor: compare each snapshot against the head of the expected queue (R12).
    always @(negedge clk) begin
        if (rst_n && snap_valid) begin
            if (exp_q.size() == 0) chk("R12 unexpected snapshot", snap_word, 16'hxxxx);
            else chk("R12 snapshot", snap_word, exp_q.pop_front());
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 word", status_word, 16'h0000);
        chk("R1 flags", {12'b0, tx_enable, snap_valid, status_irq, link_irq}, 16'h0000);

        arm();
        chk("R2 arm", status_word, 16'h0001);
        txen_wr = 1; txen_wdata = 0; step(); txen_wr = 0;
        chk("R2 disarm", status_word, 16'h0000);
        arm();

        frame_start = 1; dest_bcast = 1; step(); frame_start = 0; dest_bcast = 0;
        chk("R8 bcast", status_word, 16'h0101);
        end_frame(16'h0101);
        chk("R8 bcast held", status_word, 16'h0101);
        frame_start = 1; dest_mcast = 1; step(); frame_start = 0; dest_mcast = 0;
        chk("R8 mcast", status_word, 16'h0201);

        gap_start = 1; step(); gap_start = 0;
        ticks(7);
        carrier = 1; step(); carrier = 0;
        chk("R7 in window", status_word, 16'h0281);
        end_frame(16'h0281);
        chk("R7 cleared", status_word, 16'h0201);
        gap_start = 1; step(); gap_start = 0;
        ticks(8);
        carrier = 1; step(); carrier = 0;
        chk("R7 outside window", status_word, 16'h0201);

        frame_start = 1; step(); frame_start = 0;
        chk("R8 cleared", status_word, 16'h0001);
        ticks(64);
        coll = 1; step(); coll = 0;
        chk("R4 at 64", status_word, 16'h0001);
        ticks(1);
        coll = 1; step(); coll = 0;
        chk("R4 late", status_word, 16'h0008);
        arm();
        chk("R2 rearm clears late", status_word, 16'h0001);

        frame_start = 1; step(); frame_start = 0;
        coll = 1; repeat (15) step(); coll = 0;
        chk("R5 fifteen", status_word, 16'h0001);
        coll = 1; step(); coll = 0;
        chk("R5 sixteen", status_word, 16'h0010);
        arm();
        frame_start = 1; step(); frame_start = 0;
        coll = 1; repeat (15) step(); coll = 0;
        chk("R5 restart", status_word, 16'h0001);

        underrun = 1; txen_wr = 1; txen_wdata = 1; step();
        underrun = 0; txen_wr = 0; txen_wdata = 0;
        chk("R3 underrun beats rearm", status_word, 16'h0004);
        arm();
        chk("R2 rearm clears underrun", status_word, 16'h0001);

        full_duplex = 1; sqe_seen = 1; step(); sqe_seen = 0; full_duplex = 0;
        chk("R9 full duplex", status_word, 16'h0001);
        sqe_seen = 1; step(); sqe_seen = 0;
        chk("R9 sqe set", status_word, 16'h0021);
        arm();
        stop_on_sqe = 1; sqe_seen = 1; step(); sqe_seen = 0; stop_on_sqe = 0;
        chk("R9 stop word", status_word, 16'h0020);
        chk("R9 irq", {15'b0, status_irq}, 16'h0001);
        step();
        chk("R9 irq pulse", {15'b0, status_irq}, 16'h0000);
        arm();

        cnt_hit15 = 1; step(); cnt_hit15 = 0;
        chk("R10 set", status_word, 16'h0401);
        cnt_rd = 1; step(); cnt_rd = 0;
        chk("R10 clear", status_word, 16'h0001);
        cnt_hit15 = 1; cnt_rd = 1; step(); cnt_hit15 = 0; cnt_rd = 0;
        chk("R10 set wins", status_word, 16'h0401);
        cnt_rd = 1; step(); cnt_rd = 0;

        frame_start = 1; step(); frame_start = 0;
        defer_wait = 1;
        ticks(3036);
        chk("R6 at limit", status_word, 16'h0001);
        ticks(1);
        defer_wait = 0;
        chk("R6 excessive", status_word, 16'h0041);
        cnt_hit15 = 1;
        end_frame(16'h0441);
        cnt_hit15 = 0;
        chk("R6 cleared at end", status_word, 16'h0401);

        link_n = 0; step();
        chk("R11 link up", status_word, 16'h0403);
        chk("R11 irq", {15'b0, link_irq}, 16'h0001);
        step();
        chk("R11 irq pulse", {15'b0, link_irq}, 16'h0000);
        link_n = 1; step();
        chk("R11 link down", status_word, 16'h0401);
        chk("R11 irq down", {15'b0, link_irq}, 16'h0001);

        step();
        chk("R12 queue drained", 16'(exp_q.size()), 16'h0000);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule